// File: doc/BRIEF.md
# Flash Embedded Operation Status Generator

This block stands in for the read side of an embedded flash array while an internal program or erase runs. A command decoder upstream hands it single-cycle events: program word, sector erase, bulk erase and reset. Each event comes with a target address and a data word. While an operation is busy, every read returns a status word instead of array contents. The status word carries four flags:

- a data-polling flag;
- a toggle flag that inverts on each read;
- an error flag;
- an erase-window flag.

A small register array stands in for the real storage, so the end result of each operation can be read back.

Per-sector lock inputs block programs and erases. A test input forces an operation to fail, so the error path can be reached. Busy lengths, the erase collection window and the all-locked guard period are parameters counted in clock cycles. A 16-bit bus mode moves the flags from the low byte to the high byte.

Top module: `flash_status_gen`

## Requirements
- R1: After reset every array word reads 16'hFFFF. A read captured at one clock edge presents its word on `rd_data` from that edge on, and `rd_data` holds its value between reads.
- R2: For PROG_CYC edges after a program command, reads return status. In that status the polling flag is the complement of data bit 7 (bit 15 in wide mode). After that, reads of the target return the old word ANDed with the new one.
- R3: The toggle flag reads 0 on the first status read of an operation and inverts on each later status read, whatever the read address.
- R4: A program command whose sector is locked is ignored. The very next read returns array data, and the word stays unchanged. The sector index is the top log2(NSEC) address bits.
- R5: A program that would turn a stored 0 into a 1, or that is issued with `force_fail` high, writes nothing. After its busy period it reports status with the error flag set, and toggling continues.
- R6: A reset command in the error state clears it, and reads return array data again.
- R7: A sector erase opens a window of WIN_CYC edges. During the window the polling flag and the erase-window flag read 0. A further sector erase inside the window adds its sector and restarts the window. After the window comes an ERASE_CYC-edge phase with the erase-window flag at 1 and the polling flag at 0. After that phase, every word in each selected unlocked sector reads 16'hFFFF and all other sectors are unchanged.
- R8: If every selected sector is locked, the block reports status for GUARD_CYC edges with the polling and toggle flags at 0. It then returns to array reads with nothing erased.
- R9: A bulk erase skips the window and goes straight to the erase phase. It covers all sectors unlocked at the command.
- R10: In byte mode the polling, toggle, error and erase-window flags are bits 7, 6, 5 and 3, and the upper byte is 0. In wide mode they are bits 15, 14, 13 and 11, and the lower byte is 0. All other status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_prog | input | 1 | Decoded program-word event |
| cmd_sec_erase | input | 1 | Decoded sector-erase event |
| cmd_bulk_erase | input | 1 | Decoded bulk-erase event |
| cmd_reset | input | 1 | Decoded reset event |
| cmd_addr | input | AW | Command target address |
| cmd_data | input | 16 | Program data |
| sec_lock | input | NSEC | Per-sector lock bits |
| force_fail | input | 1 | Forces the commanded operation to fail |
| wide_mode | input | 1 | 1 selects 16-bit flag placement |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | 16 | Read result, status or array word |

## Verification
A read captured at edge k shows on `rd_data` after that edge, so the bench compares at the falling edge that follows.

Counting from the command edge, program status is due at edges 1 to PROG_CYC. Window status is due for WIN_CYC edges after the latest sector erase, erase-phase status for the ERASE_CYC edges after that, and guard status for GUARD_CYC edges after an all-locked window.

Every command and read task spends exactly one clock, so the bench knows the edge number of each read. Reads are placed at least one edge away from each phase boundary. Expected words are pushed at issue time and popped by a monitor one edge later.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int AW        = 4,
  parameter int NSEC      = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 16,
  parameter int WIN_CYC   = 10,
  parameter int GUARD_CYC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_prog,
  input  logic            cmd_sec_erase,
  input  logic            cmd_bulk_erase,
  input  logic            cmd_reset,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [15:0]     cmd_data,
  input  logic [NSEC-1:0] sec_lock,
  input  logic            force_fail,
  input  logic            wide_mode,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [15:0]     rd_data
);
  localparam int WORDS = 1 << AW;
  localparam int SW    = $clog2(NSEC);
  localparam int SPAN  = WORDS / NSEC;
  localparam int M1    = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int M2    = (WIN_CYC > GUARD_CYC) ? WIN_CYC : GUARD_CYC;
  localparam int MAXC  = (M1 > M2) ? M1 : M2;
  localparam int CW    = $clog2(MAXC + 1);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_PROG  = 3'd1;
  localparam logic [2:0] S_EWIN  = 3'd2;
  localparam logic [2:0] S_ERASE = 3'd3;
  localparam logic [2:0] S_GUARD = 3'd4;
  localparam logic [2:0] S_FAIL  = 3'd5;

  logic [15:0]     mem [WORDS];
  logic [2:0]      st;
  logic [CW-1:0]   cnt;
  logic [NSEC-1:0] sel;
  logic [AW-1:0]   p_addr;
  logic [15:0]     p_data;
  logic            fail, is_erase, tog;
  logic [WORDS-1:0] wipe;

  wire [SW-1:0]   c_sec      = cmd_addr[AW-1 -: SW];
  wire            c_locked   = sec_lock[c_sec];
  wire [NSEC-1:0] sec_onehot = NSEC'(1) << c_sec;
  wire            bad_bits   = |(cmd_data & ~mem[cmd_addr]);
  wire [NSEC-1:0] live       = sel & ~sec_lock;
  wire            in_op      = (st != S_IDLE);

  wire poll = (st == S_PROG || (st == S_FAIL && !is_erase))
              ? ~(wide_mode ? p_data[15] : p_data[7]) : 1'b0;
  wire tgl  = (st == S_GUARD) ? 1'b0 : tog;
  wire err  = (st == S_FAIL);
  wire ew   = (st == S_ERASE) || (st == S_FAIL && is_erase);
  wire [7:0]  flags     = {poll, tgl, err, 1'b0, ew, 3'b000};
  wire [15:0] stat_word = wide_mode ? {flags, 8'h00} : {8'h00, flags};

  for (genvar g = 0; g < WORDS; g++) begin : g_wipe
    assign wipe[g] = sel[g / SPAN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  sel <= '0;  p_addr <= '0;  p_data <= '0;
      fail <= 1'b0;  is_erase <= 1'b0;  tog <= 1'b0;  rd_data <= '0;
      for (int i = 0; i < WORDS; i++) mem[AW'(i)] <= '1;
    end else begin
      if (rd_en) rd_data <= in_op ? stat_word : mem[rd_addr];
      if (st == S_IDLE) tog <= 1'b0;
      else if (rd_en)   tog <= ~tog;
      case (st)
        S_IDLE: begin
          if (cmd_prog && !c_locked) begin
            st <= S_PROG;  cnt <= CW'(PROG_CYC - 1);
            p_addr <= cmd_addr;  p_data <= cmd_data;
            fail <= force_fail | bad_bits;  is_erase <= 1'b0;
          end else if (cmd_sec_erase) begin
            st <= S_EWIN;  cnt <= CW'(WIN_CYC - 1);
            sel <= sec_onehot;  fail <= force_fail;  is_erase <= 1'b1;
          end else if (cmd_bulk_erase) begin
            sel <= ~sec_lock;  fail <= force_fail;  is_erase <= 1'b1;
            if (&sec_lock) begin st <= S_GUARD; cnt <= CW'(GUARD_CYC - 1); end
            else           begin st <= S_ERASE; cnt <= CW'(ERASE_CYC - 1); end
          end
        end
        S_PROG: begin
          if (cnt == '0) begin
            if (fail) st <= S_FAIL;
            else begin
              mem[p_addr] <= mem[p_addr] & p_data;
              st <= S_IDLE;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_EWIN: begin
          if (cmd_sec_erase) begin
            sel <= sel | sec_onehot;  cnt <= CW'(WIN_CYC - 1);
            fail <= fail | force_fail;
          end else if (cnt == '0) begin
            sel <= live;
            if (live == '0) begin st <= S_GUARD; cnt <= CW'(GUARD_CYC - 1); end
            else            begin st <= S_ERASE; cnt <= CW'(ERASE_CYC - 1); end
          end else cnt <= cnt - 1'b1;
        end
        S_ERASE: begin
          if (cnt == '0) begin
            if (fail) st <= S_FAIL;
            else begin
              for (int i = 0; i < WORDS; i++)
                if (wipe[AW'(i)]) mem[AW'(i)] <= '1;
              st <= S_IDLE;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_GUARD: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_FAIL:  if (cmd_reset) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_prog,
  input logic        cmd_sec_erase,
  input logic        cmd_reset,
  input logic        rd_en,
  input logic        wide_mode,
  input logic        c_locked,
  input logic [2:0]  st,
  input logic [15:0] rd_data
);
  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_EWIN  = 3'd2;
  localparam logic [2:0] S_ERASE = 3'd3;
  localparam logic [2:0] S_GUARD = 3'd4;
  localparam logic [2:0] S_FAIL  = 3'd5;

  a_r4_locked_prog_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_prog && c_locked) |=> (st == S_IDLE));

  a_r6_reset_leaves_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAIL && cmd_reset) |=> (st == S_IDLE));

  a_r7_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EWIN && cmd_sec_erase) |=> (st == S_EWIN));

  a_r7_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wide_mode && (st == S_EWIN || st == S_ERASE)) |=> (rd_data[7] == 1'b0));

  a_r8_guard_flags_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st == S_GUARD) |=>
      ($past(wide_mode) ? (rd_data[15:14] == 2'b00) : (rd_data[7:6] == 2'b00)));

  a_r10_idle_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st != S_IDLE) |=>
      ($past(wide_mode) ? (rd_data[7:0] == 8'h00) : (rd_data[15:8] == 8'h00)));
endmodule

bind flash_status_gen flash_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_sec_erase(cmd_sec_erase),
  .cmd_reset(cmd_reset), .rd_en(rd_en), .wide_mode(wide_mode),
  .c_locked(c_locked), .st(st), .rd_data(rd_data)
);

// File: tb/flash_status_gen_test.sv
`timescale 1ns/1ps
module flash_status_gen_test;
  localparam int AW = 4, NSEC = 4, PC = 8, EC = 16, WC = 10, GC = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_prog = 0, cmd_sec_erase = 0, cmd_bulk_erase = 0, cmd_reset = 0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic [NSEC-1:0] sec_lock = '0;
  logic force_fail = 0, wide_mode = 0, rd_en = 0;
  logic [15:0] rd_data;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  flash_status_gen #(.AW(AW), .NSEC(NSEC), .PROG_CYC(PC), .ERASE_CYC(EC),
                     .WIN_CYC(WC), .GUARD_CYC(GC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_sec_erase(cmd_sec_erase),
    .cmd_bulk_erase(cmd_bulk_erase), .cmd_reset(cmd_reset), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .sec_lock(sec_lock), .force_fail(force_fail),
    .wide_mode(wide_mode), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  always @(posedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      @(negedge clk);
      total++;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s: got %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string t);
    rd_addr = a;  rd_en = 1'b1;
    exp_q.push_back(e);  tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    cmd_addr = a;  cmd_data = d;  cmd_prog = 1'b1;
    @(negedge clk);
    cmd_prog = 1'b0;
  endtask

  task automatic sec_erase(input logic [AW-1:0] a);
    cmd_addr = a;  cmd_sec_erase = 1'b1;
    @(negedge clk);
    cmd_sec_erase = 1'b0;
  endtask

  task automatic bulk_erase();
    cmd_bulk_erase = 1'b1;
    @(negedge clk);
    cmd_bulk_erase = 1'b0;
  endtask

  task automatic reset_cmd();
    cmd_reset = 1'b1;
    @(negedge clk);
    cmd_reset = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - bad, total);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;  bad++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset contents
    rd(0, 16'hFFFF, "R1 reset word 0");
    rd(15, 16'hFFFF, "R1 reset word 15");
    cyc(2);
    total++;
    if (rd_data !== 16'hFFFF) begin
      bad++;
      $display("FAIL R1 hold between reads: got %h expected %h", rd_data, 16'hFFFF);
    end

    // R2 R3 program in byte mode
    prog(1, 16'h1234);
    rd(1, 16'h0080, "R2 poll complement");
    rd(7, 16'h00C0, "R3 toggle any address");
    rd(1, 16'h0080, "R3 toggle back");
    cyc(8);
    rd(1, 16'h1234, "R2 programmed word");

    // R10 R2 wide mode program
    wide_mode = 1'b1;
    prog(5, 16'h8F0F);
    rd(5, 16'h0000, "R10 wide poll bit15");
    rd(5, 16'h4000, "R10 wide toggle bit14");
    cyc(10);
    rd(5, 16'h8F0F, "R2 wide programmed word");
    wide_mode = 1'b0;
    prog(13, 16'h0F0F);
    cyc(10);
    rd(13, 16'h0F0F, "R2 second sector word");

    // R4 locked sector program ignored
    sec_lock = 4'b0100;
    prog(8, 16'h0000);
    rd(8, 16'hFFFF, "R4 no busy on locked program");
    cyc(10);
    rd(8, 16'hFFFF, "R4 locked word unchanged");

    // R5 R6 zero-to-one attempt
    prog(1, 16'h1236);
    rd(1, 16'h0080, "R5 busy before error");
    rd(1, 16'h00C0, "R5 toggle before error");
    cyc(8);
    rd(1, 16'h00A0, "R5 error flag set");
    rd(1, 16'h00E0, "R5 error toggle continues");
    reset_cmd();
    rd(1, 16'h1234, "R6 reset returns array");

    // R5 forced failure
    force_fail = 1'b1;
    prog(2, 16'h5555);
    force_fail = 1'b0;
    rd(2, 16'h0080, "R5 forced busy");
    cyc(9);
    rd(2, 16'h00E0, "R5 forced error flag");
    reset_cmd();
    rd(2, 16'hFFFF, "R5 failed program wrote nothing");

    // R7 sector erase window with restart
    sec_lock = 4'b0000;
    sec_erase(4);
    rd(5, 16'h0000, "R7 window flags low");
    cyc(2);
    sec_erase(12);
    cyc(6);
    rd(5, 16'h0040, "R7 window restarted");
    cyc(4);
    rd(5, 16'h0008, "R7 erase phase flag");
    cyc(15);
    rd(5, 16'hFFFF, "R7 sector1 erased");
    rd(13, 16'hFFFF, "R7 sector3 erased");
    rd(1, 16'h1234, "R7 sector0 untouched");

    // R8 all selected sectors locked
    prog(9, 16'h00AA);
    cyc(10);
    sec_lock = 4'b0100;
    sec_erase(8);
    cyc(10);
    rd(9, 16'h0000, "R8 guard flags low");
    rd(9, 16'h0000, "R8 guard toggle held low");
    cyc(6);
    rd(9, 16'h00AA, "R8 nothing erased");

    // R9 R10 bulk erase in wide mode
    wide_mode = 1'b1;
    bulk_erase();
    rd(0, 16'h0800, "R9 R10 bulk erase flag bit11");
    rd(0, 16'h4800, "R9 bulk toggle");
    cyc(16);
    rd(1, 16'hFFFF, "R9 bulk erased word");
    wide_mode = 1'b0;
    rd(9, 16'h00AA, "R9 locked sector kept");

    cyc(3);
    finish_run();
  end
endmodule